// File: doc/BRIEF.md
# Power-Good and Overvoltage Supervisor

This block turns the raw comparator flags that watch a regulator's sensed output into a qualified power-good status and an overvoltage latch. A voltage window decides power-good. The sensed voltage must rise above 95% of the reference while staying under 120%. Once good, the status falls only when the voltage drops below 90%. This lower hysteresis stops chatter on a noisy output. Each transition passes through its own persistence timer, counted in system clock cycles. The rising qualification is long (about 1.28 ms), the falling one is medium (about 150 us), and the overvoltage reaction is short (about 2.5 us).

The block has two operating modes. In reference mode, used for normal or margined operation, the window alone decides power-good. In tracking mode, a second comparator pair on the tracking input must also be satisfied. It qualifies when that input stays above 0.4 V for the rising delay, and it drops as soon as the input falls below 0.3 V. Enable low forces power-good low. Overvoltage detection keeps running whatever the enable level. Once the overvoltage latch is set, it stays set until enable goes low and then high again, or until reset. A driver-off request goes out whenever enable is low or the latch is set. Every input flag is asynchronous and passes through a synchronizer of `SYNC_STAGES` flops.

Top module: `pgov_supervisor`

## Requirements
- R1: While rst_ni is low, and after it is released with enable low, pgood_o and ov_latch_o are 0 and drv_off_o is 1.
- R2: With enable high, reference mode, sns_gt_rise_i=1, sns_gt_ovp_i=0 and sns_lt_fall_i=0 held steady, pgood_o is still 0 after RISE_CYC cycles and is 1 within RISE_CYC+SYNC_STAGES+4 cycles.
- R3: An in-window pulse shorter than RISE_CYC cycles restarts the rise timer, and pgood_o stays 0.
- R4: While power-good is high, a sensed voltage between 90% and 95% (sns_gt_rise_i=0, sns_lt_fall_i=0) keeps pgood_o at 1. From a low state, the same level never raises it.
- R5: sns_lt_fall_i=1 held for FALL_CYC cycles clears pgood_o within FALL_CYC+SYNC_STAGES+4 cycles. A pulse shorter than FALL_CYC cycles leaves it high.
- R6: sns_gt_ovp_i=1 held for OVP_CYC cycles clears pgood_o and sets ov_latch_o within OVP_CYC+SYNC_STAGES+4 cycles. A shorter pulse changes neither output.
- R7: ov_latch_o stays 1 until en_i goes from 0 to 1 with no overvoltage pending. It is set even while en_i is 0.
- R8: en_i=0 forces pgood_o to 0 within SYNC_STAGES+3 cycles.
- R9: drv_off_o is 1 exactly when the synchronized enable is 0 or ov_latch_o is 1.
- R10: In tracking mode (track_mode_i=1; reference mode is 0), pgood_o needs trk_gt_on_i=1 held TRK_CYC cycles in addition to R2. With trk_gt_on_i=0 and trk_lt_off_i=0 the tracker stays qualified. trk_lt_off_i=1 clears pgood_o within SYNC_STAGES+4 cycles.
- R11: pgood_o never rises while ov_latch_o is 1, and the two are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Regulator enable |
| track_mode_i | input | 1 | 1 = tracking mode, 0 = reference mode |
| sns_gt_ovp_i | input | 1 | Sensed output above 120% |
| sns_gt_rise_i | input | 1 | Sensed output above 95% |
| sns_lt_fall_i | input | 1 | Sensed output below 90% |
| trk_gt_on_i | input | 1 | Tracking input above 0.4 V |
| trk_lt_off_i | input | 1 | Tracking input below 0.3 V |
| pgood_o | output | 1 | Qualified power-good (high = good) |
| ov_latch_o | output | 1 | Sticky overvoltage flag |
| drv_off_o | output | 1 | Request to turn both drivers off |

## Verification
Several rules are checked on every cycle. These are the exclusion between power-good and the latch, the stickiness of the latch, the forced-low effect of enable and of a lost tracker, the bound on each timer, and the timer restart. Only the bench scenarios can show the timing itself. That covers the exact hold lengths before each edge, the rejection of short pulses, the 90-95% hysteresis band from both sides, latch setting while disabled, and clearing on a fresh enable.

// File: rtl/pgov_pkg.sv
package pgov_pkg;
  typedef enum logic {
    MODE_REF   = 1'b0,
    MODE_TRACK = 1'b1
  } mode_e;

  typedef struct packed {
    logic en;
    logic mode;
    logic ovp;
    logic rise;
    logic fall;
    logic trk_on;
    logic trk_off;
  } flags_t;

  localparam int unsigned FLAGS_W = $bits(flags_t);
endpackage

// File: rtl/pgov_sync.sv
module pgov_sync #(
  parameter int unsigned W      = 7,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '0;
      else if (s == 0) stg_q[s] <= d_i;
      else stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/pgov_persist.sv
module pgov_persist #(
  parameter int unsigned DLY = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cond_i,
  output logic done_o
);
  localparam int unsigned CW = $clog2(DLY + 1);
  localparam logic [CW-1:0] LIMIT = CW'(DLY);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (!cond_i)          cnt_q <= '0;
    else if (cnt_q != LIMIT)   cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = (cnt_q == LIMIT);

  // R3 / R5 / R6: a dropped condition restarts the timer
  a_r3_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cond_i |=> !done_o);
  a_r2_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LIMIT);
  a_r2_done_needs_cond: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(cond_i));
endmodule

// File: rtl/pgov_supervisor.sv
module pgov_supervisor
  import pgov_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RISE_CYC    = 64000,
  parameter int unsigned FALL_CYC    = 7500,
  parameter int unsigned OVP_CYC     = 125,
  parameter int unsigned TRK_CYC     = 64000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic track_mode_i,
  input  logic sns_gt_ovp_i,
  input  logic sns_gt_rise_i,
  input  logic sns_lt_fall_i,
  input  logic trk_gt_on_i,
  input  logic trk_lt_off_i,
  output logic pgood_o,
  output logic ov_latch_o,
  output logic drv_off_o
);
  flags_t raw, syn;
  logic [FLAGS_W-1:0] syn_bits;

  assign raw = '{en: en_i, mode: track_mode_i, ovp: sns_gt_ovp_i,
                 rise: sns_gt_rise_i, fall: sns_lt_fall_i,
                 trk_on: trk_gt_on_i, trk_off: trk_lt_off_i};

  pgov_sync #(.W(FLAGS_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (syn_bits)
  );
  assign syn = flags_t'(syn_bits);

  mode_e mode;
  assign mode = mode_e'(syn.mode);

  logic in_win, rise_ok, fall_ok, ovp_ok, trk_on_ok;
  assign in_win = syn.rise & ~syn.ovp;

  pgov_persist #(.DLY(RISE_CYC)) u_rise (
    .clk_i(clk_i), .rst_ni(rst_ni), .cond_i(in_win), .done_o(rise_ok));
  pgov_persist #(.DLY(FALL_CYC)) u_fall (
    .clk_i(clk_i), .rst_ni(rst_ni), .cond_i(syn.fall), .done_o(fall_ok));
  pgov_persist #(.DLY(OVP_CYC)) u_ovp (
    .clk_i(clk_i), .rst_ni(rst_ni), .cond_i(syn.ovp), .done_o(ovp_ok));
  pgov_persist #(.DLY(TRK_CYC)) u_trk (
    .clk_i(clk_i), .rst_ni(rst_ni), .cond_i(syn.trk_on & syn.en), .done_o(trk_on_ok));

  // tracker: slow qualify above upper threshold, immediate drop below lower
  logic trk_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     trk_q <= 1'b0;
    else if (!syn.en || syn.trk_off) trk_q <= 1'b0;
    else if (trk_on_ok)              trk_q <= 1'b1;
  end

  logic trk_ok;
  assign trk_ok = (mode == MODE_REF) | trk_q;

  // overvoltage latch: live regardless of enable, cleared on enable rising edge
  logic en_d_q, en_rise, ov_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_d_q <= 1'b0;
    else         en_d_q <= syn.en;
  end
  assign en_rise = syn.en & ~en_d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ov_q <= 1'b0;
    else if (ovp_ok)  ov_q <= 1'b1;
    else if (en_rise) ov_q <= 1'b0;
  end

  logic pg_q, pg_kill;
  assign pg_kill = ~syn.en | ovp_ok | ov_q | fall_ok | ~trk_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                pg_q <= 1'b0;
    else if (pg_kill)           pg_q <= 1'b0;
    else if (rise_ok)           pg_q <= 1'b1;
  end

  assign pgood_o    = pg_q;
  assign ov_latch_o = ov_q;
  assign drv_off_o  = ~syn.en | ov_q;

  a_r8_en_low_kills_pg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !syn.en |=> !pgood_o);
  a_r7_latch_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ov_latch_o && !en_rise |=> ov_latch_o);
  a_r6_ovp_sets_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovp_ok |=> ov_latch_o && !pgood_o);
  a_r11_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pgood_o && ov_latch_o));
  a_r10_track_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_TRACK) && !trk_q |=> !pgood_o);
  a_r2_rise_needs_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pgood_o) |-> $past(rise_ok));
  a_r9_drv_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ov_latch_o |-> drv_off_o);
endmodule

// File: tb/test_pgov_supervisor.sv
module test_pgov_supervisor;
  localparam int unsigned SYNC = 2;
  localparam int unsigned RISE = 40;
  localparam int unsigned FALL = 12;
  localparam int unsigned OVP  = 6;
  localparam int unsigned TRK  = 30;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic en = 1'b0, trk_mode = 1'b0, ovp = 1'b0, rise = 1'b0, fall = 1'b0;
  logic trk_on = 1'b0, trk_off = 1'b0;
  logic pgood, ov_latch, drv_off;
  int   n_chk = 0, n_err = 0;
  bit   done = 1'b0;

  always #10 clk = ~clk;

  pgov_supervisor #(
    .SYNC_STAGES(SYNC), .RISE_CYC(RISE), .FALL_CYC(FALL),
    .OVP_CYC(OVP), .TRK_CYC(TRK)
  ) i_pgov_supervisor (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en), .track_mode_i(trk_mode),
    .sns_gt_ovp_i(ovp), .sns_gt_rise_i(rise), .sns_lt_fall_i(fall),
    .trk_gt_on_i(trk_on), .trk_lt_off_i(trk_off),
    .pgood_o(pgood), .ov_latch_o(ov_latch), .drv_off_o(drv_off)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // a hold of h cycles qualifies a timer of length d only if h >= d
  function automatic logic qualifies(input int h, input int d);
    return h >= d;
  endfunction

  task automatic settle_good();
    ovp = 0; fall = 0; rise = 1;
    tick(RISE + SYNC + 6);
  endtask

  initial begin
    void'($urandom(32'd1234));
    tick(3);
    chk("R1 pgood in reset", pgood, 1'b0);
    chk("R1 latch in reset", ov_latch, 1'b0);
    rst_ni = 1'b1;
    tick(4);
    chk("R1 drv_off en low", drv_off, 1'b1);
    chk("R1 pgood en low", pgood, 1'b0);

    en = 1'b1;
    tick(SYNC + 3);
    chk("R9 drv_off en high", drv_off, 1'b0);

    rise = 1'b1;
    tick(RISE);
    chk("R2 pgood before delay", pgood, 1'b0);
    tick(SYNC + 4);
    chk("R2 pgood after delay", pgood, 1'b1);

    rise = 1'b0;
    tick(RISE + 10);
    chk("R4 hysteresis band holds", pgood, 1'b1);

    fall = 1'b1; tick(FALL - 3); fall = 1'b0;
    tick(SYNC + 4);
    chk("R5 short fall pulse", pgood, 1'b1);
    fall = 1'b1; tick(FALL + SYNC + 4);
    chk("R5 fall qualified", pgood, 1'b0);
    fall = 1'b0;
    tick(RISE + 10);
    chk("R4 band does not raise", pgood, 1'b0);

    // R3: random in-window pulses
    for (int i = 0; i < 8; i++) begin
      int h;
      logic exp;
      h = (i % 2 == 0) ? 1 + int'($urandom_range(RISE - 2))
                       : RISE + SYNC + 4 + int'($urandom_range(15));
      exp = qualifies(h - SYNC - 4, RISE);
      rise = 1'b1; tick(h); rise = 1'b0;
      if (exp) begin
        chk("R3 long pulse qualifies", pgood, 1'b1);
        fall = 1'b1; tick(FALL + SYNC + 4); fall = 1'b0;
        chk("R5 reset between trials", pgood, 1'b0);
      end else begin
        tick(SYNC + 4);
        chk("R3 short pulse restarts", pgood, 1'b0);
      end
    end

    settle_good();
    chk("R2 good before ovp", pgood, 1'b1);
    ovp = 1'b1; tick(OVP - 3); ovp = 1'b0;
    tick(SYNC + 4);
    chk("R6 short ovp pgood", pgood, 1'b1);
    chk("R6 short ovp latch", ov_latch, 1'b0);
    ovp = 1'b1; tick(OVP + SYNC + 4);
    chk("R6 ovp pgood", pgood, 1'b0);
    chk("R6 ovp latch", ov_latch, 1'b1);
    chk("R9 drv_off latch", drv_off, 1'b1);
    ovp = 1'b0;
    tick(RISE + SYNC + 8);
    chk("R7 latch sticky", ov_latch, 1'b1);
    chk("R11 no pgood with latch", pgood, 1'b0);
    en = 1'b0; tick(SYNC + 4);
    chk("R7 latch holds en low", ov_latch, 1'b1);
    en = 1'b1; tick(SYNC + 4);
    chk("R7 latch cleared by enable", ov_latch, 1'b0);
    tick(RISE + 6);
    chk("R2 good after recovery", pgood, 1'b1);

    en = 1'b0; tick(SYNC + 3);
    chk("R8 en low kills pgood", pgood, 1'b0);
    chk("R9 drv_off en low", drv_off, 1'b1);
    ovp = 1'b1; tick(OVP + SYNC + 4);
    chk("R7 latch set while disabled", ov_latch, 1'b1);
    ovp = 1'b0; tick(SYNC + 4);
    en = 1'b1; tick(SYNC + 4);
    chk("R7 latch cleared after cycle", ov_latch, 1'b0);

    trk_mode = 1'b1;
    settle_good();
    chk("R10 no tracker no pgood", pgood, 1'b0);
    trk_on = 1'b1; tick(TRK);
    chk("R10 tracker before delay", pgood, 1'b0);
    tick(SYNC + 5);
    chk("R10 tracker qualified", pgood, 1'b1);
    trk_on = 1'b0; tick(20);
    chk("R10 tracker hysteresis", pgood, 1'b1);
    trk_off = 1'b1; tick(SYNC + 4);
    chk("R10 tracker lost", pgood, 1'b0);
    trk_off = 1'b0;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(20 * 50000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule